// File: doc/BRIEF.md
# Encoded-Function Logic Unit with Bus Release

This block is a small logic unit that shares a data bus with other devices. It takes two operands and a 2-bit function code. A decoder turns the code into separate active-high enables, one per operation, so only one result can ever be gated onto the bus. Three of the codes put the bitwise XOR, AND or OR of the operands on the bus.

The remaining code, zero, is not a fourth operation. It means "idle": the decoder asserts no enable, and the block releases its output to high impedance. Another device on the same bus can then drive it. A `bus_drive` flag shows whether the block is currently driving.

A parameter chooses the timing. With registering on (the default), the result and the drive flag are captured at the clock edge, and both appear one cycle after the inputs. With registering off, the path is combinational.

Top module: `alu_bus_unit`

## Requirements
- R1: Function code 2'b01 places the bitwise XOR of `opnd_a` and `opnd_b` on `alu_bus`.
- R2: Function code 2'b10 places the bitwise AND of `opnd_a` and `opnd_b` on `alu_bus`.
- R3: Function code 2'b11 places the bitwise OR of `opnd_a` and `opnd_b` on `alu_bus`.
- R4: Function code 2'b00 releases every bit of `alu_bus` to high impedance and drives `bus_drive` low.
- R5: At most one operation enable is asserted at any time, and exactly one is asserted for each non-zero code.
- R6: `bus_drive` is high for every non-zero function code.
- R7: With `REG_OUT`=1, `alu_bus` and `bus_drive` reflect the operands and code sampled at the preceding rising clock edge.
- R8: While `rst` is high at a rising edge, the registered stage returns to the released state, so `bus_drive` is low and the bus is left free.
- R9: While the block is released, a value driven onto the bus by another device is seen on the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| func_code | input | 2 | Function code: 00 idle, 01 XOR, 10 AND, 11 OR |
| bus_drive | output | 1 | High while the block drives `alu_bus` |
| alu_bus | output | W | Tri-state result output to the shared bus |

## Verification
On every cycle, assertions check the following:
- The decoder never asserts two enables, and it asserts exactly one for each non-zero code.
- The registered drive flag follows the code of the previous cycle.
- Reset always leaves the block released.
- The selected XOR result matches the registered operands.

Only the bench scenarios can show the bus-level behaviour. These scenarios put a second driver on a shared net. They show that this driver's value comes through unchanged whenever the code is idle. They also show that the result of each operation is correct across all operand pairs.

// File: rtl/alu_bus_pkg.sv
package alu_bus_pkg;
  typedef enum logic [1:0] {
    FN_IDLE = 2'b00,
    FN_XOR  = 2'b01,
    FN_AND  = 2'b10,
    FN_OR   = 2'b11
  } func_e;

  typedef struct packed {
    logic en_xor;
    logic en_and;
    logic en_or;
  } op_enables_t;
endpackage

// File: rtl/func_decoder.sv
module func_decoder
  import alu_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  code,
  output op_enables_t enables
);
  logic [3:0] dec_lines;

  always_comb begin
    dec_lines = 4'b0000;
    dec_lines[code] = 1'b1;
  end

  // line 0 (idle) is deliberately left unused
  assign enables.en_xor = dec_lines[FN_XOR];
  assign enables.en_and = dec_lines[FN_AND];
  assign enables.en_or  = dec_lines[FN_OR];

  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enables.en_xor, enables.en_and, enables.en_or})); // R5
  AST_ENABLE_PRESENT: assert property (@(posedge clk) disable iff (rst)
    (code != 2'b00) |-> ($countones({enables.en_xor, enables.en_and, enables.en_or}) == 1)); // R5
endmodule

// File: rtl/logic_unit.sv
module logic_unit
  import alu_bus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_enables_t  enables,
  output logic [W-1:0] result,
  output logic         active
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign result[i] = (enables.en_xor & (a[i] ^ b[i]))
                     | (enables.en_and & (a[i] & b[i]))
                     | (enables.en_or  & (a[i] | b[i]));
  end

  assign active = enables.en_xor | enables.en_and | enables.en_or;
endmodule

// File: rtl/bus_driver.sv
module bus_driver #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic [W-1:0] data,
  output logic [W-1:0] bus
);
  assign bus = drive ? data : {W{1'bz}};
endmodule

// File: rtl/alu_bus_unit.sv
module alu_bus_unit
  import alu_bus_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   func_code,
  output logic         bus_drive,
  output logic [W-1:0] alu_bus
);
  op_enables_t  enables;
  logic [W-1:0] comb_result;
  logic         comb_active;
  logic [W-1:0] out_data;
  logic         out_drive;

  func_decoder u_dec (
    .clk     (clk),
    .rst     (rst),
    .code    (func_code),
    .enables (enables)
  );

  logic_unit #(.W(W)) u_logic (
    .a       (opnd_a),
    .b       (opnd_b),
    .enables (enables),
    .result  (comb_result),
    .active  (comb_active)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] data_q;
    logic         drive_q;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [1:0]   code_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q  <= '0;
        drive_q <= 1'b0;
        a_q     <= '0;
        b_q     <= '0;
        code_q  <= FN_IDLE;
      end else begin
        data_q  <= comb_result;
        drive_q <= comb_active;
        a_q     <= opnd_a;
        b_q     <= opnd_b;
        code_q  <= func_code;
      end
    end

    assign out_data  = data_q;
    assign out_drive = drive_q;

    AST_DRIVE_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (drive_q == ($past(func_code) != 2'b00))); // R7
    AST_RESET_RELEASES: assert property (@(posedge clk)
      $past(rst) |-> !drive_q); // R8
    AST_XOR_RESULT: assert property (@(posedge clk) disable iff (rst)
      (drive_q && code_q == FN_XOR) |-> (data_q == (a_q ^ b_q))); // R1
  end else begin : g_comb
    assign out_data  = comb_result;
    assign out_drive = comb_active;
  end

  bus_driver #(.W(W)) u_drv (
    .drive (out_drive),
    .data  (out_data),
    .bus   (alu_bus)
  );

  assign bus_drive = out_drive;
endmodule

// File: tb/sim_alu_bus_unit.sv
`timescale 1ns/1ps
module sim_alu_bus_unit;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [1:0]   func_code = 2'b00;
  logic         bus_drive;
  wire  [W-1:0] shared_bus;
  logic         other_en = 1'b0;
  logic [W-1:0] other_val = '0;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  assign shared_bus = other_en ? other_val : {W{1'bz}};

  alu_bus_unit #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk       (clk),
    .rst       (rst),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .func_code (func_code),
    .bus_drive (bus_drive),
    .alu_bus   (shared_bus)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    // Reset: the registered stage must be released, and another device owns the bus (R8, R9)
    repeat (3) @(negedge clk);
    other_en  = 1'b1;
    other_val = 4'b1010;
    #1;
    chk("R8", {3'b000, bus_drive}, 4'b0000);
    chk("R8", shared_bus, 4'b1010);
    @(negedge clk);
    rst = 1'b0;
    other_en = 1'b0;

    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          logic [W-1:0] ea;
          logic [W-1:0] eb;
          logic [W-1:0] exp_v;
          @(negedge clk);
          ea = W'(a);
          eb = W'(b);
          opnd_a    = ea;
          opnd_b    = eb;
          func_code = 2'(c);
          other_en  = 1'b0;
          @(posedge clk);
          #0.5;
          // The output now shows the inputs captured at this edge (R7)
          if (c == 0) begin
            other_val = ~(ea ^ 4'b0110);
            other_en  = 1'b1;
            #0.5;
            chk("R4", {3'b000, bus_drive}, 4'b0000);
            chk("R9", shared_bus, other_val);
          end else begin
            #0.5;
            case (c)
              1: exp_v = ea ^ eb;
              2: exp_v = ea & eb;
              default: exp_v = ea | eb;
            endcase
            chk("R6", {3'b000, bus_drive}, 4'b0001);
            if (c == 1) chk("R1", shared_bus, exp_v);
            else if (c == 2) chk("R2", shared_bus, exp_v);
            else chk("R3", shared_bus, exp_v);
          end
        end
      end
    end

    // Latency: the output holds until the next edge, then releases (R7, R4)
    @(negedge clk);
    other_en  = 1'b0;
    opnd_a    = 4'b1100;
    opnd_b    = 4'b1010;
    func_code = 2'b11;
    @(posedge clk);
    #1;
    chk("R7", shared_bus, 4'b1110);
    @(negedge clk);
    func_code = 2'b00;
    #0.5;
    chk("R7", shared_bus, 4'b1110);
    @(posedge clk);
    #0.5;
    other_en  = 1'b1;
    other_val = 4'b0011;
    #0.5;
    chk("R4", {3'b000, bus_drive}, 4'b0000);
    chk("R9", shared_bus, 4'b0011);

    // A synchronous reset in the middle of a run releases the bus (R8)
    @(negedge clk);
    other_en  = 1'b0;
    func_code = 2'b10;
    @(posedge clk);
    #1;
    chk("R2", shared_bus, 4'b1000);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R8", {3'b000, bus_drive}, 4'b0000);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule